// File: doc/BRIEF.md
# Frame Scrubber for Configuration Memory

The block holds a small configuration store of 16 frames, each eight 32-bit words, as a register array. Each frame has a 16-bit reference check code. While enabled, the scrubber reads the frames in ascending order and wraps after the last one. It folds every frame through a CRC and compares the result with that frame's reference. On a mismatch it searches for the single bit that explains the difference, flips that bit back, and resumes scanning. When no single bit explains the difference, it raises a sticky uncorrectable flag and freezes until a synchronous reset, which stands in for a full reload of the device.

Host software fills the store through a valid/ready write stream. It then pulses `seal` to compute the references and raises `run` to start scanning. A fault-injection port inverts one chosen bit, but only while the scrubber is paused. The block pauses only between frames. A combinational peek port lets the host read any word at any time.

The write stream has no buffering. `ld_ready` is high exactly when the scrubber is paused. A word is written on every clock edge where `ld_valid` and `ld_ready` are both high. While the scrubber is scanning, sealing, repairing or halted, the producer must hold its word.

Top module: `cfg_scrubber`

## Requirements
- R1: After a synchronous reset, the scrubber is paused: `st_observe`, `st_correct` and `st_uncorr` are low, `ld_ready` is high, every word reads zero, and each reference equals the code of an all-zero frame, so scanning the cleared store finds no fault.
- R2: `ld_ready` is high only while paused. A word is written to (`ld_frame`, `ld_word`) on each clock edge where `ld_valid` and `ld_ready` are both high, and it is visible on the peek port afterwards.
- R3: A `seal` pulse while paused recomputes the references for frames 0 to 15, taking 8 cycles per frame. It then leaves the scan pointer on frame 0 and pauses again. The code is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, fed word 0 to word 7, most significant bit first. `seal` takes priority over `run`.
- R4: While `run` is high, frames are checked in ascending order, wrapping from 15 to 0. Each check takes 9 cycles, and `st_observe` is high throughout. When `run` is low, the scrubber pauses at the next frame boundary.
- R5: While paused, `inj_en` inverts exactly bit `inj_bit` of word (`inj_frame`, `inj_word`). Injection has no effect while the scrubber is not paused, or in a cycle in which a write handshake also happens.
- R6: A frame with a single flipped bit is repaired in place, and its original contents are restored. During the search (at most 256 cycles), `st_correct` is high and `fault_frame` holds the index of the failing frame.
- R7: When a correction attempt ends, the block goes directly to observation (`st_observe` high) unless the error was found uncorrectable.
- R8: If no single-bit flip matches the reference, `st_uncorr` goes high and stays high until reset. Scanning stops, the frame is left unmodified, `ld_ready` stays low, and injection is ignored.
- R9: At most one of `st_observe`, `st_correct` and `st_uncorr` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also models reconfiguration |
| run | input | 1 | Scanning enable; pause takes effect at a frame boundary |
| seal | input | 1 | Pulse while paused to recompute all reference codes |
| ld_valid | input | 1 | Write stream valid |
| ld_ready | output | 1 | Write stream ready (high only while paused) |
| ld_frame | input | 4 | Write frame index |
| ld_word | input | 3 | Write word index |
| ld_data | input | 32 | Write data |
| inj_en | input | 1 | Fault-injection strobe |
| inj_frame | input | 4 | Injection frame index |
| inj_word | input | 3 | Injection word index |
| inj_bit | input | 5 | Injection bit index |
| peek_frame | input | 4 | Peek frame index |
| peek_word | input | 3 | Peek word index |
| peek_data | output | 32 | Current content of the peeked word |
| st_observe | output | 1 | Scanning status |
| st_correct | output | 1 | Repair in progress |
| st_uncorr | output | 1 | Sticky uncorrectable flag |
| fault_frame | output | 4 | Index of the most recent frame that failed its check |

## Verification
The hardest state to reach is an uncorrectable frame. It requires two bits flipped inside one frame while the references still describe the clean data. Every injection must also happen while paused, because injection is ignored otherwise. The bench therefore seals the clean store first, which also returns the scan pointer to frame 0 so that the order of events is known. It then injects both flips while paused and raises `run`. It expects one repair attempt on that frame, followed by the sticky flag. Injections at the first and last bit positions of the search confirm that both ends of the locator are reachable.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [2:0] {
    SC_IDLE, SC_SCAN, SC_CHECK, SC_FIX, SC_SEAL, SC_HALT
  } scrub_state_e;

  // One serial CRC step, message bit b shifted in.
  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction

  // Code of an all-zero message of nbits bits.
  function automatic logic [15:0] crc_zero(input int nbits);
    logic [15:0] c;
    c = CRC_INIT;
    for (int i = 0; i < nbits; i++) c = crc_bit(c, 1'b0);
    return c;
  endfunction
endpackage

// File: rtl/scrub_store.sv
module scrub_store
  import scrub_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int WORDS  = 8,
  parameter int WIDTH  = 32,
  localparam int FW = $clog2(FRAMES),
  localparam int WW = $clog2(WORDS),
  localparam int BW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FW-1:0]    scan_f,
  input  logic [WW-1:0]    scan_w,
  output logic [WIDTH-1:0] scan_data,
  input  logic [FW-1:0]    peek_f,
  input  logic [WW-1:0]    peek_w,
  output logic [WIDTH-1:0] peek_data,
  input  logic             wr_en,
  input  logic [FW-1:0]    wr_f,
  input  logic [WW-1:0]    wr_w,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             flip_en,
  input  logic [FW-1:0]    flip_f,
  input  logic [WW-1:0]    flip_w,
  input  logic [BW-1:0]    flip_b,
  input  logic [FW-1:0]    ref_f,
  output logic [15:0]      ref_q,
  input  logic             ref_we,
  input  logic [15:0]      ref_d
);
  localparam int DEPTH = FRAMES * WORDS;
  localparam logic [15:0] REF_RST = crc_zero(WORDS * WIDTH);

  logic [WIDTH-1:0] mem  [DEPTH];
  logic [15:0]      refs [FRAMES];

  assign scan_data = mem[{scan_f, scan_w}];
  assign peek_data = mem[{peek_f, peek_w}];
  assign ref_q     = refs[ref_f];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int j = 0; j < FRAMES; j++) refs[j] <= REF_RST;
    end else begin
      if (wr_en) mem[{wr_f, wr_w}] <= wr_data;
      if (flip_en)
        mem[{flip_f, flip_w}] <= mem[{flip_f, flip_w}] ^ (WIDTH'(1) << flip_b);
      if (ref_we) refs[ref_f] <= ref_d;
    end
  end
endmodule

// File: rtl/scrub_crc_acc.sv
module scrub_crc_acc
  import scrub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [WIDTH-1:0] data,
  output logic [15:0]      crc_q,
  output logic [15:0]      crc_next
);
  always_comb begin
    logic [15:0] c;
    c = crc_q;
    for (int i = WIDTH - 1; i >= 0; i--) c = crc_bit(c, data[i]);
    crc_next = c;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= CRC_INIT;
    else if (en)    crc_q <= crc_next;
  end
endmodule

// File: rtl/scrub_locator.sv
module scrub_locator
  import scrub_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WIDTH = 32,
  localparam int WW = $clog2(WORDS),
  localparam int BW = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          step,
  input  logic [15:0]   syn_in,
  output logic          hit,
  output logic          last,
  output logic [WW-1:0] loc_w,
  output logic [BW-1:0] loc_b
);
  logic [15:0] syn_q;
  logic [15:0] cand_q;

  // Walks bit positions from the last one fed to the first, carrying the
  // signature of a lone error at each position.
  always_ff @(posedge clk) begin
    if (rst) begin
      syn_q  <= '0;
      cand_q <= CRC_POLY;
      loc_w  <= '0;
      loc_b  <= '0;
    end else if (start) begin
      syn_q  <= syn_in;
      cand_q <= CRC_POLY;
      loc_w  <= WW'(WORDS - 1);
      loc_b  <= '0;
    end else if (step) begin
      cand_q <= crc_bit(cand_q, 1'b0);
      if (loc_b == BW'(WIDTH - 1)) begin
        loc_b <= '0;
        loc_w <= loc_w - 1'b1;
      end else begin
        loc_b <= loc_b + 1'b1;
      end
    end
  end

  assign hit  = (cand_q == syn_q);
  assign last = (loc_w == '0) && (loc_b == BW'(WIDTH - 1));
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int WORDS  = 8,
  parameter int WIDTH  = 32,
  localparam int FW = $clog2(FRAMES),
  localparam int WW = $clog2(WORDS),
  localparam int BW = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          seal,
  input  logic          ld_valid,
  input  logic          inj_en,
  input  logic [FW-1:0] inj_f,
  input  logic [WW-1:0] inj_w,
  input  logic [BW-1:0] inj_b,
  input  logic [15:0]   crc_q,
  input  logic [15:0]   crc_next,
  input  logic [15:0]   ref_q,
  input  logic          hit,
  input  logic          last,
  input  logic [WW-1:0] loc_w,
  input  logic [BW-1:0] loc_b,
  output logic          ld_ready,
  output logic          wr_en,
  output logic          flip_en,
  output logic [FW-1:0] flip_f,
  output logic [WW-1:0] flip_w,
  output logic [BW-1:0] flip_b,
  output logic [FW-1:0] frame,
  output logic [WW-1:0] word,
  output logic          crc_clr,
  output logic          crc_en,
  output logic          ref_we,
  output logic [15:0]   ref_d,
  output logic          loc_start,
  output logic          loc_step,
  output logic          st_observe,
  output logic          st_correct,
  output logic          st_uncorr,
  output logic [FW-1:0] fault_frame
);
  localparam logic [WW-1:0] LAST_W = WW'(WORDS - 1);
  localparam logic [FW-1:0] LAST_F = FW'(FRAMES - 1);

  scrub_state_e state;
  logic         mismatch;

  assign mismatch   = (crc_q != ref_q);
  assign st_observe = (state == SC_SCAN) || (state == SC_CHECK);
  assign st_correct = (state == SC_FIX);
  assign st_uncorr  = (state == SC_HALT);
  assign ld_ready   = (state == SC_IDLE);
  assign ref_d      = crc_next;

  always_comb begin
    wr_en     = 1'b0;
    flip_en   = 1'b0;
    flip_f    = inj_f;
    flip_w    = inj_w;
    flip_b    = inj_b;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    ref_we    = 1'b0;
    loc_start = 1'b0;
    loc_step  = 1'b0;
    unique case (state)
      SC_IDLE: begin
        wr_en   = ld_valid;
        flip_en = inj_en && !ld_valid;
        crc_clr = seal || run;
      end
      SC_SCAN: crc_en = 1'b1;
      SC_SEAL: begin
        crc_en = 1'b1;
        if (word == LAST_W) begin
          ref_we  = 1'b1;
          crc_clr = 1'b1;
        end
      end
      SC_CHECK: begin
        if (mismatch) loc_start = 1'b1;
        else          crc_clr   = run;
      end
      SC_FIX: begin
        if (hit) begin
          flip_en = 1'b1;
          flip_f  = frame;
          flip_w  = loc_w;
          flip_b  = loc_b;
          crc_clr = 1'b1;
        end else if (!last) begin
          loc_step = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SC_IDLE;
      frame       <= '0;
      word        <= '0;
      fault_frame <= '0;
    end else begin
      unique case (state)
        SC_IDLE: begin
          word <= '0;
          if (seal) begin
            frame <= '0;
            state <= SC_SEAL;
          end else if (run) begin
            state <= SC_SCAN;
          end
        end
        SC_SCAN: begin
          word <= word + 1'b1;
          if (word == LAST_W) state <= SC_CHECK;
        end
        SC_SEAL: begin
          word <= word + 1'b1;
          if (word == LAST_W) begin
            frame <= frame + 1'b1;
            if (frame == LAST_F) state <= SC_IDLE;
          end
        end
        SC_CHECK: begin
          word <= '0;
          if (mismatch) begin
            fault_frame <= frame;
            state       <= SC_FIX;
          end else begin
            frame <= frame + 1'b1;
            state <= run ? SC_SCAN : SC_IDLE;
          end
        end
        SC_FIX: begin
          if (hit) begin
            frame <= frame + 1'b1;
            state <= SC_SCAN;
          end else if (last) begin
            state <= SC_HALT;
          end
        end
        default: state <= SC_HALT;
      endcase
    end
  end
endmodule

// File: rtl/cfg_scrubber.sv
module cfg_scrubber #(
  parameter int FRAMES = 16,
  parameter int WORDS  = 8,
  parameter int WIDTH  = 32,
  localparam int FW = $clog2(FRAMES),
  localparam int WW = $clog2(WORDS),
  localparam int BW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             seal,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [FW-1:0]    ld_frame,
  input  logic [WW-1:0]    ld_word,
  input  logic [WIDTH-1:0] ld_data,
  input  logic             inj_en,
  input  logic [FW-1:0]    inj_frame,
  input  logic [WW-1:0]    inj_word,
  input  logic [BW-1:0]    inj_bit,
  input  logic [FW-1:0]    peek_frame,
  input  logic [WW-1:0]    peek_word,
  output logic [WIDTH-1:0] peek_data,
  output logic             st_observe,
  output logic             st_correct,
  output logic             st_uncorr,
  output logic [FW-1:0]    fault_frame
);
  logic             wr_en, flip_en, crc_clr, crc_en, ref_we;
  logic             loc_start, loc_step, hit, last;
  logic [FW-1:0]    flip_f, frame;
  logic [WW-1:0]    flip_w, word, loc_w;
  logic [BW-1:0]    flip_b, loc_b;
  logic [15:0]      crc_q, crc_next, ref_q, ref_d;
  logic [WIDTH-1:0] scan_data;

  scrub_store #(.FRAMES(FRAMES), .WORDS(WORDS), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst),
    .scan_f(frame), .scan_w(word), .scan_data(scan_data),
    .peek_f(peek_frame), .peek_w(peek_word), .peek_data(peek_data),
    .wr_en(wr_en), .wr_f(ld_frame), .wr_w(ld_word), .wr_data(ld_data),
    .flip_en(flip_en), .flip_f(flip_f), .flip_w(flip_w), .flip_b(flip_b),
    .ref_f(frame), .ref_q(ref_q), .ref_we(ref_we), .ref_d(ref_d)
  );

  scrub_crc_acc #(.WIDTH(WIDTH)) u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .data(scan_data),
    .crc_q(crc_q), .crc_next(crc_next)
  );

  scrub_locator #(.WORDS(WORDS), .WIDTH(WIDTH)) u_loc (
    .clk(clk), .rst(rst), .start(loc_start), .step(loc_step),
    .syn_in(crc_q ^ ref_q), .hit(hit), .last(last), .loc_w(loc_w), .loc_b(loc_b)
  );

  scrub_ctrl #(.FRAMES(FRAMES), .WORDS(WORDS), .WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .run(run), .seal(seal), .ld_valid(ld_valid),
    .inj_en(inj_en), .inj_f(inj_frame), .inj_w(inj_word), .inj_b(inj_bit),
    .crc_q(crc_q), .crc_next(crc_next), .ref_q(ref_q),
    .hit(hit), .last(last), .loc_w(loc_w), .loc_b(loc_b),
    .ld_ready(ld_ready), .wr_en(wr_en), .flip_en(flip_en),
    .flip_f(flip_f), .flip_w(flip_w), .flip_b(flip_b),
    .frame(frame), .word(word), .crc_clr(crc_clr), .crc_en(crc_en),
    .ref_we(ref_we), .ref_d(ref_d), .loc_start(loc_start), .loc_step(loc_step),
    .st_observe(st_observe), .st_correct(st_correct), .st_uncorr(st_uncorr),
    .fault_frame(fault_frame)
  );
endmodule

// File: rtl/scrub_checker.sv
module scrub_checker #(
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          st_observe,
  input logic          st_correct,
  input logic          st_uncorr,
  input logic          ld_ready,
  input logic [FW-1:0] fault_frame
);
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_observe, st_correct, st_uncorr})); // R9

  AST_UNCORR_STICKY: assert property (@(posedge clk) disable iff (rst)
    st_uncorr |=> st_uncorr); // R8

  AST_HALT_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (rst)
    st_uncorr |-> !ld_ready); // R8

  AST_READY_WHEN_PAUSED: assert property (@(posedge clk) disable iff (rst)
    ld_ready |-> !(st_observe || st_correct)); // R2

  AST_REPAIR_RETURNS: assert property (@(posedge clk) disable iff (rst)
    $fell(st_correct) |-> (st_observe || st_uncorr)); // R7

  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (st_correct && $past(st_correct)) |-> $stable(fault_frame)); // R6
endmodule

bind cfg_scrubber scrub_checker #(.FW(FW)) u_chk (
  .clk(clk), .rst(rst), .st_observe(st_observe), .st_correct(st_correct),
  .st_uncorr(st_uncorr), .ld_ready(ld_ready), .fault_frame(fault_frame)
);

// File: tb/sim_cfg_scrubber.sv
module sim_cfg_scrubber;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0, seal = 1'b0, ld_valid = 1'b0, inj_en = 1'b0;
  logic        ld_ready;
  logic [3:0]  ld_frame = '0, inj_frame = '0, peek_frame = '0;
  logic [2:0]  ld_word = '0, inj_word = '0, peek_word = '0;
  logic [4:0]  inj_bit = '0;
  logic [31:0] ld_data = '0, peek_data;
  logic        st_observe, st_correct, st_uncorr;
  logic [3:0]  fault_frame;

  int n_vec = 0, n_err = 0;
  bit done = 0;
  int exp_kind[$];
  int exp_frame[$];

  always #4 clk = ~clk;

  cfg_scrubber u0 (.*);

  function automatic logic [31:0] pat(input int f, input int w);
    return 32'h3C00_0000 | (f << 16) | (w << 8) | ((f * 17 + w * 5) & 8'hFF);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; run = 1'b0;
    cycles(3);
    rst = 1'b0;
  endtask

  task automatic load(input int f, input int w, input logic [31:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_frame = 4'(f); ld_word = 3'(w); ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic inject(input int f, input int w, input int b);
    @(negedge clk);
    inj_en = 1'b1; inj_frame = 4'(f); inj_word = 3'(w); inj_bit = 5'(b);
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic do_seal();
    @(negedge clk); seal = 1'b1;
    @(negedge clk); seal = 1'b0;
    cycles(16 * 8 + 2);
  endtask

  task automatic pause();
    @(negedge clk); run = 1'b0;
    while (!ld_ready) @(negedge clk);
  endtask

  task automatic peek_chk(input string req, input int f, input int w, input logic [31:0] exp);
    @(negedge clk);
    peek_frame = 4'(f); peek_word = 3'(w);
    #1;
    chk(req, peek_data, exp);
  endtask

  // driver side of the scoreboard: 1 = repair attempt, 2 = uncorrectable
  task automatic expect_event(input int kind, input int f);
    exp_kind.push_back(kind);
    exp_frame.push_back(f);
  endtask

  task automatic drain();
    while (exp_kind.size() != 0) @(negedge clk);
    cycles(4);
  endtask

  // monitor side of the scoreboard
  logic pc = 1'b0, pu = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      pc <= 1'b0; pu <= 1'b0;
    end else begin
      if (st_correct && !pc) begin
        if (exp_kind.size() == 0) chk("R6 unexpected repair", 1, 0);
        else begin
          chk("R6 event kind", 1, exp_kind.pop_front());
          chk("R6 fault_frame", 32'(fault_frame), exp_frame.pop_front());
        end
      end
      if (!st_correct && pc) chk("R7 back to observe", 32'(st_observe || st_uncorr), 1);
      if (st_uncorr && !pu) begin
        if (exp_kind.size() == 0) chk("R8 unexpected halt", 2, 0);
        else begin
          chk("R8 event kind", 2, exp_kind.pop_front());
          chk("R8 fault_frame", 32'(fault_frame), exp_frame.pop_front());
        end
      end
      pc <= st_correct;
      pu <= st_uncorr;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 observe", 32'(st_observe), 0);
    chk("R1 correct", 32'(st_correct), 0);
    chk("R1 uncorr", 32'(st_uncorr), 0);
    chk("R1 ready", 32'(ld_ready), 1);
    peek_chk("R1 cleared word", 3, 2, 0);

    // cleared store scans clean against reset references
    @(negedge clk); run = 1'b1;
    cycles(3);
    chk("R4 observe while running", 32'(st_observe), 1);
    chk("R2 ready low while running", 32'(ld_ready), 0);
    cycles(300);
    pause();
    chk("R4 paused at boundary", 32'(ld_ready), 1);

    // load and seal
    for (int f = 0; f < 16; f++)
      for (int w = 0; w < 8; w++) load(f, w, pat(f, w));
    peek_chk("R2 readback", 0, 0, pat(0, 0));
    peek_chk("R2 readback", 11, 6, pat(11, 6));
    peek_chk("R2 readback", 15, 7, pat(15, 7));
    do_seal();
    chk("R3 idle after seal", 32'(ld_ready), 1);
    @(negedge clk); run = 1'b1;
    cycles(320);
    pause();

    // R4 order and R6 search ends: pointer at frame 0 after seal
    do_seal();
    inject(15, 7, 0);
    inject(0, 0, 31);
    peek_chk("R5 flip applied", 0, 0, pat(0, 0) ^ 32'h8000_0000);
    expect_event(1, 0);
    expect_event(1, 15);
    @(negedge clk); run = 1'b1;
    drain();
    pause();
    peek_chk("R6 repaired first bit", 0, 0, pat(0, 0));
    peek_chk("R6 repaired last bit", 15, 7, pat(15, 7));
    chk("R7 no uncorr", 32'(st_uncorr), 0);

    // R5 injection is a pure XOR
    inject(5, 3, 17);
    peek_chk("R5 single flip", 5, 3, pat(5, 3) ^ 32'h0002_0000);
    inject(5, 3, 17);
    peek_chk("R5 double flip restores", 5, 3, pat(5, 3));
    inject(5, 3, 17);
    expect_event(1, 5);
    @(negedge clk); run = 1'b1;
    drain();
    pause();
    peek_chk("R6 mid-frame repair", 5, 3, pat(5, 3));

    // R5 ignored while running
    @(negedge clk); run = 1'b1;
    cycles(2);
    inj_en = 1'b1; inj_frame = 4'd2; inj_word = 3'd1; inj_bit = 5'd4;
    cycles(50);
    inj_en = 1'b0;
    cycles(300);
    pause();
    peek_chk("R5 ignored while running", 2, 1, pat(2, 1));

    // R5 ignored in a write handshake cycle
    @(negedge clk);
    ld_valid = 1'b1; ld_frame = 4'd4; ld_word = 3'd2; ld_data = 32'h1234_5678;
    inj_en = 1'b1; inj_frame = 4'd4; inj_word = 3'd2; inj_bit = 5'd0;
    @(negedge clk);
    ld_valid = 1'b0; inj_en = 1'b0;
    peek_chk("R5 ignored with load", 4, 2, 32'h1234_5678);
    load(4, 2, pat(4, 2));

    // R8 two flips in one frame
    do_seal();
    inject(9, 1, 3);
    inject(9, 6, 30);
    expect_event(1, 9);
    expect_event(2, 9);
    @(negedge clk); run = 1'b1;
    drain();
    chk("R8 uncorr set", 32'(st_uncorr), 1);
    chk("R8 scan stopped", 32'(st_observe), 0);
    chk("R8 ready low", 32'(ld_ready), 0);
    cycles(400);
    chk("R8 uncorr sticky", 32'(st_uncorr), 1);
    peek_chk("R8 frame untouched", 9, 1, pat(9, 1) ^ 32'h0000_0008);
    inject(9, 1, 3);
    peek_chk("R8 injection ignored", 9, 1, pat(9, 1) ^ 32'h0000_0008);

    // reset stands in for reconfiguration
    do_reset();
    @(negedge clk);
    chk("R1 uncorr cleared", 32'(st_uncorr), 0);
    chk("R1 ready after reset", 32'(ld_ready), 1);
    peek_chk("R1 store cleared", 9, 1, 0);
    chk("R6 scoreboard empty", exp_kind.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_err++;
      $display("FAIL watchdog actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule